// File: doc/BRIEF.md
# Open-Drain Status Pin Source Selector

This block drives one open-drain status pin. In normal operation a 3-bit selection code picks what the pin shows. The choices are an unlock flag, a one-shot measurement-completion indicator, the level of either of two general-purpose I/O pins, or a released pin. The output `pull_low` is a registered, active-high enable for the pull-down transistor. A logic 1 on the pin is shown by releasing it, so `pull_low` is 0.

Serial bus activity takes priority over the selection code. While chip-enable is high in write mode, the pin is released. While chip-enable is high in read mode, the pin carries the inverted read-back bit, which is refreshed on each falling edge of the bus clock. The completion indicator is armed by a rising edge of the count-start bit and set by a completion event. It then holds until the next count start or until the selection code changes. All inputs are synchronous to `clk`.

Top module: `status_pin_sel`

## Requirements
- R1: With `bus_ce` low, codes 000, 011, 100 and 111 give `pull_low` = 0 one cycle after they are applied, whatever the other inputs are.
- R2: With `bus_ce` low and code 001, `pull_low` equals the `unlock_flag` value sampled one clock edge earlier.
- R3: A 0-to-1 change of `count_start` (comparing successive edges) clears the completion indicator and arms it. A `meas_done` pulse while the indicator is armed sets it and disarms it. With code 010 and `bus_ce` low, `pull_low` goes to 1 two edges after the `meas_done` edge and goes to 0 two edges after the start edge.
- R4: Once set, the completion indicator holds until the next rising edge of `count_start`, or until `sel_code` differs from its value at the previous edge. A code change also disarms it. A `meas_done` pulse while the indicator is not armed is ignored.
- R5: With `bus_ce` low, code 101 selects I/O pin 0 and code 110 selects I/O pin 1. When the selected pin's `gpio_is_out` bit is 0, `pull_low` = NOT `gpio_in[k]`. When that bit is 1, `pull_low` = 0.
- R6: `bus_ce` = 1 with `bus_rd_mode` = 0 (write) gives `pull_low` = 0 one cycle later, whatever the code.
- R7: `bus_ce` = 1 with `bus_rd_mode` = 1 (read) gives `pull_low` = NOT `rd_bit`, loaded on the first edge of the read transfer and at each edge where `bus_clk` is 0 after being 1 at the previous edge. `pull_low` holds between those edges, whatever the code.
- R8: Synchronous reset `rst` gives `pull_low` = 0 and leaves the completion indicator cleared and unarmed.
- R9: A count-start rising edge and a `meas_done` pulse in the same cycle leave the indicator cleared and armed. A completion event during a bus transfer is still recorded and appears once `bus_ce` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_code | input | 3 | Pin source selection code |
| bus_ce | input | 1 | Serial bus chip-enable (transfer active) |
| bus_clk | input | 1 | Serial bus clock, sampled by `clk` |
| bus_rd_mode | input | 1 | 1 = read transfer, 0 = write transfer |
| rd_bit | input | 1 | Current serial read-back data bit |
| unlock_flag | input | 1 | Unlock condition detected |
| count_start | input | 1 | Count start control bit |
| meas_done | input | 1 | Measurement completion pulse |
| gpio_in | input | 2 | Levels of the two general-purpose I/O pins |
| gpio_is_out | input | 2 | Direction of each I/O pin, 1 = output |
| pull_low | output | 1 | Pull-down enable of the status pin |

## Verification
Two pairs of events can land in the same cycle. The first pair is a count-start rising edge and a completion pulse. The bench raises both on one edge and expects the pin to stay released, then sends a lone pulse later and expects the pin to pull low. The second pair is a completion pulse and an active write transfer. The bench sends the pulse while chip-enable is high, expects the pin to stay released for as long as the transfer lasts, and expects the pull-low to appear one edge after chip-enable falls.

// File: rtl/status_pin_pkg.sv
package status_pin_pkg;
  localparam int CODE_W = 3;
  localparam int IO_BASE = 5;

  typedef enum logic [CODE_W-1:0] {
    SEL_OPEN_A = 3'd0,
    SEL_UNLOCK = 3'd1,
    SEL_DONE   = 3'd2,
    SEL_OPEN_B = 3'd3,
    SEL_OPEN_C = 3'd4,
    SEL_IO0    = 3'd5,
    SEL_IO1    = 3'd6,
    SEL_OPEN_D = 3'd7
  } sel_e;
endpackage

// File: rtl/spin_done_tracker.sv
module spin_done_tracker
  import status_pin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] sel_code,
  input  logic              count_start,
  input  logic              meas_done,
  output logic              done_flag
);
  logic              start_q;
  logic [CODE_W-1:0] code_q;
  logic              armed;
  logic              start_rise;
  logic              code_moved;

  assign start_rise = count_start && !start_q;
  assign code_moved = (sel_code != code_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q   <= 1'b0;
      code_q    <= '0;
      armed     <= 1'b0;
      done_flag <= 1'b0;
    end else begin
      start_q <= count_start;
      code_q  <= sel_code;
      if (start_rise) begin
        armed     <= 1'b1;
        done_flag <= 1'b0;
      end else if (code_moved) begin
        armed     <= 1'b0;
        done_flag <= 1'b0;
      end else if (meas_done && armed) begin
        armed     <= 1'b0;
        done_flag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spin_src_mux.sv
module spin_src_mux
  import status_pin_pkg::*;
#(
  parameter int N_IO = 2
) (
  input  logic [CODE_W-1:0] sel_code,
  input  logic              unlock_flag,
  input  logic              done_flag,
  input  logic [N_IO-1:0]   gpio_in,
  input  logic [N_IO-1:0]   gpio_is_out,
  output logic              pull_req
);
  logic [N_IO-1:0] io_pull;
  logic [N_IO-1:0] io_hit;

  for (genvar k = 0; k < N_IO; k++) begin : g_io
    assign io_hit[k]  = (sel_code == CODE_W'(IO_BASE + k));
    assign io_pull[k] = io_hit[k] && !gpio_is_out[k] && !gpio_in[k];
  end

  always_comb begin
    case (sel_code)
      SEL_UNLOCK: pull_req = unlock_flag;
      SEL_DONE:   pull_req = done_flag;
      default:    pull_req = |io_pull;
    endcase
  end
endmodule

// File: rtl/spin_out_stage.sv
module spin_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic bus_ce,
  input  logic bus_clk,
  input  logic bus_rd_mode,
  input  logic rd_bit,
  input  logic pull_req,
  output logic pull_low
);
  logic bclk_q;
  logic rd_active_q;
  logic rd_now;
  logic bclk_fall;

  assign rd_now    = bus_ce && bus_rd_mode;
  assign bclk_fall = bclk_q && !bus_clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q      <= 1'b0;
      rd_active_q <= 1'b0;
      pull_low    <= 1'b0;
    end else begin
      bclk_q      <= bus_clk;
      rd_active_q <= rd_now;
      if (bus_ce && !bus_rd_mode) begin
        pull_low <= 1'b0;
      end else if (rd_now) begin
        if (!rd_active_q || bclk_fall) pull_low <= !rd_bit;
      end else begin
        pull_low <= pull_req;
      end
    end
  end
endmodule

// File: rtl/status_pin_sel.sv
module status_pin_sel
  import status_pin_pkg::*;
#(
  parameter int N_IO = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] sel_code,
  input  logic              bus_ce,
  input  logic              bus_clk,
  input  logic              bus_rd_mode,
  input  logic              rd_bit,
  input  logic              unlock_flag,
  input  logic              count_start,
  input  logic              meas_done,
  input  logic [N_IO-1:0]   gpio_in,
  input  logic [N_IO-1:0]   gpio_is_out,
  output logic              pull_low
);
  logic done_flag;
  logic pull_req;

  spin_done_tracker u_track (
    .clk(clk), .rst(rst), .sel_code(sel_code),
    .count_start(count_start), .meas_done(meas_done),
    .done_flag(done_flag)
  );

  spin_src_mux #(.N_IO(N_IO)) u_mux (
    .sel_code(sel_code), .unlock_flag(unlock_flag), .done_flag(done_flag),
    .gpio_in(gpio_in), .gpio_is_out(gpio_is_out), .pull_req(pull_req)
  );

  spin_out_stage u_out (
    .clk(clk), .rst(rst), .bus_ce(bus_ce), .bus_clk(bus_clk),
    .bus_rd_mode(bus_rd_mode), .rd_bit(rd_bit), .pull_req(pull_req),
    .pull_low(pull_low)
  );
endmodule

// File: rtl/status_pin_sel_chk.sv
module status_pin_sel_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] sel_code,
  input logic       bus_ce,
  input logic       bus_clk,
  input logic       bus_rd_mode,
  input logic       rd_bit,
  input logic       unlock_flag,
  input logic       count_start,
  input logic [1:0] gpio_is_out,
  input logic       done_flag,
  input logic       pull_low
);
  assert_open_codes_R1: assert property (@(posedge clk) disable iff (rst)
    (!bus_ce && (sel_code == 3'd0 || sel_code == 3'd3 || sel_code == 3'd4 || sel_code == 3'd7))
    |=> !pull_low);

  assert_unlock_follow_R2: assert property (@(posedge clk) disable iff (rst)
    (!bus_ce && sel_code == 3'd1) |=> (pull_low == $past(unlock_flag)));

  assert_start_clears_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(count_start) |=> !done_flag);

  assert_flag_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (done_flag && !$rose(count_start) && $stable(sel_code)) |=> done_flag);

  assert_io_out_release_R5: assert property (@(posedge clk) disable iff (rst)
    (!bus_ce && ((sel_code == 3'd5 && gpio_is_out[0]) || (sel_code == 3'd6 && gpio_is_out[1])))
    |=> !pull_low);

  assert_write_release_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_ce && !bus_rd_mode) |=> !pull_low);

  assert_read_edge_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_ce && bus_rd_mode && $fell(bus_clk)) |=> (pull_low == !$past(rd_bit)));

  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> (!pull_low && !done_flag));
endmodule

bind status_pin_sel status_pin_sel_chk u_chk (
  .clk(clk), .rst(rst), .sel_code(sel_code), .bus_ce(bus_ce), .bus_clk(bus_clk),
  .bus_rd_mode(bus_rd_mode), .rd_bit(rd_bit), .unlock_flag(unlock_flag),
  .count_start(count_start), .gpio_is_out(gpio_is_out), .done_flag(done_flag),
  .pull_low(pull_low)
);

// File: tb/test_status_pin_sel.sv
module test_status_pin_sel;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sel_code = 3'd0;
  logic       bus_ce = 1'b0, bus_clk = 1'b0, bus_rd_mode = 1'b0, rd_bit = 1'b0;
  logic       unlock_flag = 1'b0, count_start = 1'b0, meas_done = 1'b0;
  logic [1:0] gpio_in = 2'b00, gpio_is_out = 2'b00;
  logic       pull_low;
  int n_chk = 0, n_bad = 0;
  bit done_run = 1'b0;

  always #2.5 clk = ~clk;

  status_pin_sel i_status_pin_sel (
    .clk(clk), .rst(rst), .sel_code(sel_code), .bus_ce(bus_ce), .bus_clk(bus_clk),
    .bus_rd_mode(bus_rd_mode), .rd_bit(rd_bit), .unlock_flag(unlock_flag),
    .count_start(count_start), .meas_done(meas_done), .gpio_in(gpio_in),
    .gpio_is_out(gpio_is_out), .pull_low(pull_low)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input logic exp, input string req);
    n_chk++;
    if (pull_low !== exp) begin
      n_bad++;
      $display("FAIL %s: pull_low=%b expected=%b", req, pull_low, exp);
    end
  endtask

  task automatic arm_and_finish();
    count_start = 1'b1; tick();
    count_start = 1'b0;
    meas_done = 1'b1; tick();
    meas_done = 1'b0; tick();
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done_run) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic e;
    sel_code = 3'd1; unlock_flag = 1'b1;
    tick(); tick();
    check(1'b0, "R8 reset state");
    rst = 1'b0;

    // Sweep codes x unlock x pin levels x directions; indicator never armed
    for (int c = 0; c < 8; c++)
      for (int u = 0; u < 2; u++)
        for (int gi = 0; gi < 4; gi++)
          for (int go = 0; go < 4; go++) begin
            sel_code = 3'(c); unlock_flag = u[0];
            gpio_in = 2'(gi); gpio_is_out = 2'(go);
            tick();
            if (c == 1) e = u[0];
            else if (c == 5) e = !go[0] && !gi[0];
            else if (c == 6) e = !go[1] && !gi[1];
            else e = 1'b0;
            if (c == 1) check(e, "R2 unlock sweep");
            else if (c == 5 || c == 6) check(e, "R5 io sweep");
            else if (c == 2) check(e, "R4 unarmed indicator");
            else check(e, "R1 open sweep");
          end

    // R3: arm then complete
    sel_code = 3'd2; unlock_flag = 1'b0; tick();
    count_start = 1'b1; tick(); tick();
    check(1'b0, "R3 released after start");
    meas_done = 1'b1; tick();
    meas_done = 1'b0;
    check(1'b0, "R3 one edge after done");
    tick();
    check(1'b1, "R3 low two edges after done");
    count_start = 1'b0;
    repeat (3) tick();
    check(1'b1, "R4 holds after start falls");
    count_start = 1'b1; tick(); tick();
    check(1'b0, "R3 next start releases");
    count_start = 1'b0; tick();

    // R4: second done without re-arm ignored
    arm_and_finish(); tick();
    check(1'b1, "R4 setup");
    meas_done = 1'b1; tick(); meas_done = 1'b0; tick();
    check(1'b1, "R4 extra done");
    // code change clears
    sel_code = 3'd0; tick(); sel_code = 3'd2; tick(); tick();
    check(1'b0, "R4 code change clears");
    meas_done = 1'b1; tick(); meas_done = 1'b0; tick(); tick();
    check(1'b0, "R4 done after code change ignored");

    // R9: start rise and done in the same cycle
    count_start = 1'b1; meas_done = 1'b1; tick();
    meas_done = 1'b0; tick(); tick();
    check(1'b0, "R9 start wins over done");
    meas_done = 1'b1; tick(); meas_done = 1'b0; tick();
    check(1'b1, "R9 later done sets");
    count_start = 1'b0; tick();

    // R9: done during a write transfer
    count_start = 1'b1; tick(); count_start = 1'b0; tick();
    bus_ce = 1'b1; bus_rd_mode = 1'b0; tick();
    meas_done = 1'b1; tick(); meas_done = 1'b0; tick(); tick();
    check(1'b0, "R6 write transfer released");
    bus_ce = 1'b0; tick();
    check(1'b1, "R9 done recorded during transfer");

    // R6 with unlock code
    sel_code = 3'd1; unlock_flag = 1'b1; tick();
    check(1'b1, "R2 unlock low");
    bus_ce = 1'b1; tick();
    check(1'b0, "R6 write overrides unlock");

    // R7 read transfer
    bus_ce = 1'b0; tick();
    bus_clk = 1'b1; rd_bit = 1'b0; bus_ce = 1'b1; bus_rd_mode = 1'b1; unlock_flag = 1'b0;
    tick();
    check(1'b1, "R7 first read load");
    rd_bit = 1'b1; tick();
    check(1'b1, "R7 hold without clock fall");
    bus_clk = 1'b0; tick();
    check(1'b0, "R7 load on clock fall");
    rd_bit = 1'b0; tick();
    check(1'b0, "R7 hold while clock low");
    bus_clk = 1'b1; tick();
    check(1'b0, "R7 hold on clock rise");
    bus_clk = 1'b0; tick();
    check(1'b1, "R7 second fall load");
    bus_ce = 1'b0; bus_rd_mode = 1'b0; tick();
    check(1'b0, "R2 back to selection");

    // R8 mid-run reset
    unlock_flag = 1'b1; tick();
    rst = 1'b1; tick();
    check(1'b0, "R8 mid-run reset");
    rst = 1'b0; sel_code = 3'd2; tick(); tick();
    meas_done = 1'b1; tick(); meas_done = 1'b0; tick(); tick();
    check(1'b0, "R8 unarmed after reset");

    done_run = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule